// File: doc/BRIEF.md
# Zero-Suppressed Event Memory Readout

This block holds hit events for a 64-channel front end and sends them out as a serial bit stream. Each accepted trigger stores a 12-bit bunch-crossing number and the 64-bit hit pattern in a small event memory. A trigger on which every channel fired counts as noisy and is thrown away. A mode input picks what happens when the memory is full. In the first mode the earliest events are kept and later triggers are dropped. In the second mode the memory works as a ring and the newest events replace the oldest.

A one-cycle start pulse begins a readout. The block first sends its chip identifier, MSB first. It then sends each stored event, oldest first: a header word, followed by one word per fired channel in ascending channel order. Channels that did not fire produce no words. Every word is 16 bits and is sent MSB first. When the memory is empty, a second mode input decides what happens: either nothing is sent, or the chip identifier alone is sent. After the last bit the block pulses done for one cycle and empties its memory.

Top module: `zsr_readout`

## Requirements
- R1: Only channels that fired produce a hit word. The hit words of one event follow its header in ascending channel order.
- R2: With `roll_mode`=0 and 8 events already stored, a further trigger is dropped, so the first 8 events are the ones read out.
- R3: With `roll_mode`=1 and 8 events already stored, a further trigger replaces the oldest event, so the last 8 events are read out, oldest first.
- R4: A trigger on which all 64 channels fired stores nothing.
- R5: With an empty memory and `always_id`=0, a start gives no bits. Done pulses in the cycle after the start edge, and busy stays low.
- R6: With an empty memory and `always_id`=1, a start sends only the 8 chip-ID bits.
- R7: The stream is: chip ID (8 bits, MSB first), then for each event its header word and then its hit words. Each word is sent MSB first.
- R8: Header word: bit 15 = 0, bits 14:3 = bunch-crossing ID, bits 2:1 = 0. Hit word: bit 15 = 1, bits 14:9 = channel number, bits 8:1 = the event's position in the readout (0 = oldest).
- R9: Bit 0 of every word is set so that bits 15:0 together hold an even number of ones.
- R10: Busy is high for exactly one cycle per stream bit, and `sdo` carries one bit per busy cycle. Done is a one-cycle pulse in the cycle after the last bit, with busy low. The memory is empty after done. After reset, busy, done and `sdo` are low.
- R11: A trigger is ignored while busy or done is high, and in the cycle in which a start is accepted.
- R12: A start is ignored while a readout is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| roll_mode | input | 1 | 0 keeps the first events, 1 keeps the last events (ring) |
| always_id | input | 1 | 1 sends the chip ID even when the memory is empty |
| chip_id | input | 8 | Identifier sent at the start of a readout |
| trig | input | 1 | Trigger strobe, one event per cycle high |
| hits | input | 64 | Hit pattern sampled with the trigger |
| bcid | input | 12 | Bunch-crossing ID sampled with the trigger |
| start | input | 1 | Readout request pulse |
| busy | output | 1 | High while stream bits are being sent |
| sdo | output | 1 | Serial data, one bit per busy cycle |
| done | output | 1 | One-cycle pulse ending a readout |

## Verification
The bench builds the block with its default values: 64 channels, 8 event slots and an 8-bit chip ID. At these values the full-channel noisy pattern and the 63-hit maximum event can be driven directly. Overflowing the memory in both modes takes only about a dozen triggers, and a full memory of densely hit events produces a stream of several thousand bits. The ring wrap, the drop-on-full path and the readout ordinal field (bits 8:1) that counts 0 to 7 can therefore all be reached within one short run.

// File: rtl/zsr_pkg.sv
// Shared types and word packing for the zero-suppressed readout.
// Assumes 16-bit words whose bit 0 is an even-parity bit over bits 15:1.
package zsr_pkg;

    localparam int WORD_W = 16;
    localparam int BCID_W = 12;
    localparam int CHF_W  = 6;   // channel field width in a hit word
    localparam int ORD_W  = 8;   // event ordinal field width in a hit word

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_ID   = 2'd1,
        RD_WORD = 2'd2,
        RD_FIN  = 2'd3
    } rd_state_e;

    // Append the even-parity bit to a 15-bit word body.
    function automatic logic [WORD_W-1:0] seal_word(input logic [WORD_W-2:0] body);
        return {body, ^body};
    endfunction

endpackage

// File: rtl/zsr_event_store.sv
// Event memory: DEPTH slots of {hit pattern, bunch-crossing ID}.
// Drops noisy (all channels hit) triggers. When full it either drops new
// triggers (keep-first) or overwrites the oldest slot (keep-last ring).
// Assumes DEPTH is a power of two and at least 2. Reads are combinational,
// indexed by ordinal from the oldest stored event.
module zsr_event_store
    import zsr_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int DEPTH  = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              roll_mode,
    input  logic [NUM_CH-1:0] wr_hits,
    input  logic [BCID_W-1:0] wr_bcid,
    input  logic              clear,
    input  logic [PTR_W-1:0]  rd_ord,
    output logic [NUM_CH-1:0] rd_hits,
    output logic [BCID_W-1:0] rd_bcid,
    output logic [CNT_W-1:0]  count
);

    logic [NUM_CH-1:0] hit_mem  [DEPTH];
    logic [BCID_W-1:0] bcid_mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  base_ptr;
    logic              noisy;
    logic              has_room;
    logic              do_write;
    logic [PTR_W-1:0]  rd_slot;

    assign noisy    = &wr_hits;
    assign has_room = (count < CNT_W'(DEPTH));
    assign do_write = wr_en && !noisy && (has_room || roll_mode);
    assign rd_slot  = base_ptr + rd_ord;
    assign rd_hits  = hit_mem[rd_slot];
    assign rd_bcid  = bcid_mem[rd_slot];

    // Pointer and occupancy bookkeeping for both fill modes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr   <= '0;
            base_ptr <= '0;
            count    <= '0;
        end else if (do_write) begin
            wr_ptr <= wr_ptr + PTR_W'(1);
            if (has_room) begin
                count <= count + CNT_W'(1);
            end else begin
                base_ptr <= base_ptr + PTR_W'(1);
            end
        end
    end

    // Slot storage; contents are only meaningful below the occupancy count.
    always_ff @(posedge clk) begin
        if (do_write) begin
            hit_mem[wr_ptr]  <= wr_hits;
            bcid_mem[wr_ptr] <= wr_bcid;
        end
    end

endmodule

// File: rtl/zsr_readout_seq.sv
// Readout sequencer: on start sends the chip ID, then each stored event as a
// header word and one hit word per fired channel (ascending), one bit per
// clock MSB first. Ends with a one-cycle done that clears the memory.
// Assumes ID_W < 16 and NUM_CH <= 64 so fields fit the word format.
module zsr_readout_seq
    import zsr_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int DEPTH  = 8,
    parameter int ID_W   = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              always_id,
    input  logic [ID_W-1:0]   chip_id,
    input  logic [CNT_W-1:0]  ev_count,
    input  logic [NUM_CH-1:0] rd_hits,
    input  logic [BCID_W-1:0] rd_bcid,
    output logic [PTR_W-1:0]  rd_ord,
    output logic              lock,
    output logic              busy,
    output logic              sdo,
    output logic              done
);

    rd_state_e         state;
    logic [3:0]        bit_cnt;
    logic [WORD_W-1:0] sh;
    logic [NUM_CH-1:0] rem;
    logic [PTR_W-1:0]  ev_ord;
    logic [CH_W-1:0]   low_ch;
    logic              more_ev;
    logic [WORD_W-1:0] hdr_word;
    logic [WORD_W-1:0] hit_word;

    // Lowest remaining fired channel of the current event.
    always_comb begin
        low_ch = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (rem[i]) low_ch = CH_W'(i);
        end
    end

    assign more_ev  = (CNT_W'(ev_ord) + CNT_W'(1)) < ev_count;
    assign rd_ord   = (state == RD_WORD) ? ev_ord + PTR_W'(1) : '0;
    assign hdr_word = seal_word({1'b0, rd_bcid, 2'b00});
    assign hit_word = seal_word({1'b1, CHF_W'(low_ch), ORD_W'(ev_ord)});
    assign busy     = (state == RD_ID) || (state == RD_WORD);
    assign done     = (state == RD_FIN);
    assign sdo      = busy && sh[WORD_W-1];
    assign lock     = (state != RD_IDLE) || start;

    // Stream state machine and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RD_IDLE;
            bit_cnt <= '0;
            sh      <= '0;
            rem     <= '0;
            ev_ord  <= '0;
        end else begin
            case (state)
                RD_IDLE: begin
                    if (start) begin
                        bit_cnt <= '0;
                        if (ev_count != '0 || always_id) begin
                            sh    <= WORD_W'(chip_id) << (WORD_W - ID_W);
                            state <= RD_ID;
                        end else begin
                            state <= RD_FIN;
                        end
                    end
                end
                RD_ID: begin
                    sh      <= sh << 1;
                    bit_cnt <= bit_cnt + 4'd1;
                    if (bit_cnt == 4'(ID_W - 1)) begin
                        bit_cnt <= '0;
                        if (ev_count != '0) begin
                            sh     <= hdr_word;
                            rem    <= rd_hits;
                            ev_ord <= '0;
                            state  <= RD_WORD;
                        end else begin
                            state <= RD_FIN;
                        end
                    end
                end
                RD_WORD: begin
                    sh      <= sh << 1;
                    bit_cnt <= bit_cnt + 4'd1;
                    if (bit_cnt == 4'd15) begin
                        if (|rem) begin
                            sh  <= hit_word;
                            rem <= rem & (rem - NUM_CH'(1));
                        end else if (more_ev) begin
                            sh     <= hdr_word;
                            rem    <= rd_hits;
                            ev_ord <= ev_ord + PTR_W'(1);
                        end else begin
                            state <= RD_FIN;
                        end
                    end
                end
                default: begin
                    state <= RD_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/zsr_readout.sv
// Top of the zero-suppressed event memory readout. Gates triggers while a
// readout runs or is being requested, and ties the store to the sequencer.
module zsr_readout
    import zsr_pkg::*;
#(
    parameter int NUM_CH = 64,
    parameter int DEPTH  = 8,
    parameter int ID_W   = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              roll_mode,
    input  logic              always_id,
    input  logic [ID_W-1:0]   chip_id,
    input  logic              trig,
    input  logic [NUM_CH-1:0] hits,
    input  logic [BCID_W-1:0] bcid,
    input  logic              start,
    output logic              busy,
    output logic              sdo,
    output logic              done
);

    logic              lock;
    logic              accept;
    logic [CNT_W-1:0]  ev_count;
    logic [PTR_W-1:0]  rd_ord;
    logic [NUM_CH-1:0] rd_hits;
    logic [BCID_W-1:0] rd_bcid;

    assign accept = trig && !lock;

    zsr_event_store #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (accept),
        .roll_mode(roll_mode),
        .wr_hits  (hits),
        .wr_bcid  (bcid),
        .clear    (done),
        .rd_ord   (rd_ord),
        .rd_hits  (rd_hits),
        .rd_bcid  (rd_bcid),
        .count    (ev_count)
    );

    zsr_readout_seq #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .ID_W(ID_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .always_id(always_id),
        .chip_id  (chip_id),
        .ev_count (ev_count),
        .rd_hits  (rd_hits),
        .rd_bcid  (rd_bcid),
        .rd_ord   (rd_ord),
        .lock     (lock),
        .busy     (busy),
        .sdo      (sdo),
        .done     (done)
    );

endmodule

// File: rtl/zsr_readout_chk.sv
// Protocol and occupancy checks for zsr_readout, bound to every instance.
module zsr_readout_chk #(
    parameter int NUM_CH = 64,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              roll_mode,
    input logic              always_id,
    input logic              trig,
    input logic [NUM_CH-1:0] hits,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [CNT_W-1:0]  ev_count
);

    // R10
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    clear_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ev_count == '0));

    // R11
    busy_ignores_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ev_count));

    // R4
    noisy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && (&hits) && !busy && !done && !start) |=> $stable(ev_count));

    // R2
    keep_first_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!roll_mode && ev_count == CNT_W'(DEPTH) && !done) |=> (ev_count == CNT_W'(DEPTH)));

    // R3
    ring_stays_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_mode && trig && !busy && !done && !start && ev_count == CNT_W'(DEPTH))
        |=> (ev_count == CNT_W'(DEPTH)));

    // R5
    empty_no_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && ev_count == '0 && !always_id) |=> (done && !busy));

    // R6
    empty_with_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && always_id) |=> busy);

    // R2
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_count <= CNT_W'(DEPTH));

endmodule

bind zsr_readout zsr_readout_chk #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .roll_mode(roll_mode),
    .always_id(always_id),
    .trig     (trig),
    .hits     (hits),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .ev_count (ev_count)
);

// File: tb/tb_zsr_readout.sv
// Bench for zsr_readout: directed corner cases plus seeded random rounds,
// compared against a bit stream built from a queue model of the events.
module tb_zsr_readout;

    localparam int MAXB = 9000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        roll_mode = 1'b0;
    logic        always_id = 1'b0;
    logic [7:0]  chip_id = 8'hA5;
    logic        trig = 1'b0;
    logic [63:0] hits = '0;
    logic [11:0] bcid = '0;
    logic        start = 1'b0;
    logic        busy;
    logic        sdo;
    logic        done;

    int total = 0;
    int fails = 0;

    logic [63:0] m_hits [8];
    logic [11:0] m_bcid [8];
    int          m_cnt = 0;

    logic exp_bits [MAXB];
    logic got_bits [MAXB];
    int   exp_len;
    int   got_len;

    always #4 clk = ~clk;

    zsr_readout dut (
        .clk(clk), .rst_n(rst_n), .roll_mode(roll_mode), .always_id(always_id),
        .chip_id(chip_id), .trig(trig), .hits(hits), .bcid(bcid),
        .start(start), .busy(busy), .sdo(sdo), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // Queue model of the event memory.
    task automatic model_push(input logic [63:0] h, input logic [11:0] b);
        if (&h) return;
        if (m_cnt < 8) begin
            m_hits[m_cnt] = h; m_bcid[m_cnt] = b; m_cnt++;
        end else if (roll_mode) begin
            for (int i = 0; i < 7; i++) begin
                m_hits[i] = m_hits[i+1]; m_bcid[i] = m_bcid[i+1];
            end
            m_hits[7] = h; m_bcid[7] = b;
        end
    endtask

    function automatic logic [15:0] mk_word(input logic [14:0] body);
        int ones = 0;
        for (int i = 0; i < 15; i++) ones += int'(body[i]);
        return {body, ones[0]};
    endfunction

    task automatic put_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) begin
            exp_bits[exp_len] = w[i]; exp_len++;
        end
    endtask

    task automatic build_expected();
        exp_len = 0;
        if (m_cnt == 0 && !always_id) return;
        for (int i = 7; i >= 0; i--) begin
            exp_bits[exp_len] = chip_id[i]; exp_len++;
        end
        for (int e = 0; e < m_cnt; e++) begin
            put_word(mk_word({1'b0, m_bcid[e], 2'b00}));
            for (int c = 0; c < 64; c++) begin
                if (m_hits[e][c]) put_word(mk_word({1'b1, 6'(c), 8'(e)}));
            end
        end
    endtask

    // Called at a negedge: one trigger over the next posedge.
    task automatic fire(input logic [63:0] h, input logic [11:0] b);
        trig = 1'b1; hits = h; bcid = b;
        model_push(h, b);
        @(negedge clk);
        trig = 1'b0;
    endtask

    function automatic logic [63:0] sparse_hits();
        logic [63:0] a = {$urandom, $urandom};
        logic [63:0] b = {$urandom, $urandom};
        logic [63:0] c = {$urandom, $urandom};
        return a & b & c;
    endfunction

    // Start a readout, collect the stream and compare. inject drives junk
    // triggers and starts while busy.
    task automatic readout(input string req, input bit inject);
        int cyc = 0;
        int gaps = 0;
        int first_bad = -1;
        build_expected();
        got_len = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        forever begin
            cyc++;
            if (done) break;
            if (busy) begin
                if (got_len < MAXB) got_bits[got_len] = sdo;
                got_len++;
                if (inject) begin
                    trig = 1'b1; hits = sparse_hits(); bcid = 12'($urandom);
                    start = 1'($urandom);
                end
            end else begin
                gaps++;
            end
            if (cyc > MAXB + 10) break;
            @(negedge clk);
            trig = 1'b0; start = 1'b0;
        end
        check(done && !busy, "R10", "done with busy low at end", int'(done), 1);
        check(gaps == 0, "R10", "idle cycles inside readout", gaps, 0);
        check(got_len == exp_len, req, "stream length (R10)", got_len, exp_len);
        for (int i = 0; i < exp_len && i < got_len; i++) begin
            if (got_bits[i] !== exp_bits[i] && first_bad < 0) first_bad = i;
        end
        check(first_bad < 0, req, "first mismatching bit index (R7 R8 R9)", first_bad, -1);
        if (exp_len == 0) check(cyc == 1, "R5", "cycles to done when empty", cyc, 1);
        m_cnt = 0;
        @(negedge clk);
        check(!done, "R10", "done lasts one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(!busy && !done && !sdo, "R10", "outputs after reset",
              int'({busy, done, sdo}), 0);

        // R5 empty without ID
        always_id = 1'b0;
        readout("R5", 1'b0);

        // R6 empty with ID
        always_id = 1'b1; chip_id = 8'h3C;
        readout("R6", 1'b0);

        // R1 R7 R8 R9 single event, edge channels
        fire(64'h8000_0000_0010_0001, 12'hABC);
        readout("R1", 1'b0);

        // R4 noisy trigger between two normal ones; 63-hit event kept
        fire(64'h0000_0000_0000_0006, 12'h001);
        fire('1, 12'h002);
        fire(64'h7FFF_FFFF_FFFF_FFFF, 12'h003);
        readout("R4", 1'b0);

        // R2 keep-first with overflow
        roll_mode = 1'b0;
        for (int i = 0; i < 11; i++) fire(64'h1 << i, 12'(i + 16));
        readout("R2", 1'b0);

        // R3 keep-last ring with overflow and wrap
        roll_mode = 1'b1;
        for (int i = 0; i < 13; i++) fire(64'h3 << (2 * i), 12'(i + 100));
        readout("R3", 1'b0);

        // R11 R12 junk triggers and starts while busy, then empty readout
        fire(64'h0F0, 12'h055);
        readout("R12", 1'b1);
        always_id = 1'b1;
        readout("R11", 1'b0);

        // R11 trigger in the same cycle as an accepted start
        trig = 1'b1; hits = 64'h1; bcid = 12'h77;
        readout("R11", 1'b0);
        always_id = 1'b0;
        readout("R11", 1'b0);

        // Random rounds
        for (int r = 0; r < 24; r++) begin
            int n = int'($urandom % 13);
            roll_mode = 1'($urandom);
            always_id = 1'($urandom);
            chip_id = 8'($urandom);
            for (int t = 0; t < n; t++) begin
                int k = int'($urandom % 10);
                logic [63:0] h = (k == 0) ? '1 : (k == 1) ? '0 : sparse_hits();
                fire(h, 12'($urandom));
                if ($urandom % 3 == 0) @(negedge clk);
            end
            readout(roll_mode ? "R3" : "R2", 1'($urandom));
        end
        summary();
    end

endmodule